// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of an 8-bit controller's multiplexed external bus. The address-latch strobe `ale` is active high and tells external logic when to capture the low address byte. The code-fetch read strobe `psen_n` is active low. The block runs on the oscillator clock and divides it into machine cycles of twelve oscillator periods. Each strobe pulse lasts two periods and sits at a fixed phase inside the machine cycle.

The core tells the block what the current machine cycle is doing through four level inputs:
- an external data access is in progress;
- code is being executed from external memory;
- a code-move or data-move instruction is running;
- the address-latch strobe is disabled by configuration.

The block samples these inputs once, on the clock edge that starts each machine cycle, and holds them for the whole cycle. A pulse therefore never gets cut short.

In the normal case the address-latch strobe repeats every six oscillator periods. An external data cycle removes one of its pulses, and also removes both fetch-strobe pulses of that cycle. When the disable bit is set, the address-latch strobe stays at its idle high level for the whole cycle. The exceptions are move-instruction cycles and cycles executing from external memory, where the disable bit has no effect.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high, `ale` is 0 and `psen_n` is 1 from the clock edge after `rst` is seen.
- R2: The first clock edge after reset release starts phase 0. Every later edge advances the phase by one, modulo 12. With the strobe enabled and no external data access, `ale` is 1 in phases 0, 1, 6 and 7 and 0 in all other phases.
- R3: In a cycle where `xdata_cyc` was sampled as 1 and `ale` is enabled, the pulse in phases 6 and 7 is omitted (`ale`=0). The pulse in phases 0 and 1 is kept.
- R4: In a cycle with `xexec`=1 and `xdata_cyc`=0, `psen_n` is 0 in phases 3, 4, 9 and 10 and 1 elsewhere. Each low pulse therefore spans exactly two periods.
- R5: In a cycle with `xdata_cyc`=1, `psen_n` stays 1 for all twelve phases, whatever the value of `xexec`.
- R6: In a cycle with `xexec`=0, `psen_n` stays 1 for all twelve phases.
- R7: In a cycle with `ale_off`=1, `xexec`=0 and `move_cyc`=0, `ale` is held at 1 for all twelve phases.
- R8: In a cycle with `ale_off`=1 and `move_cyc`=1, `ale` follows R2 and R3 exactly as if `ale_off` were 0.
- R9: In a cycle with `xexec`=1, `ale_off` has no effect on `ale`.
- R10: The inputs `xdata_cyc`, `xexec`, `move_cyc` and `ale_off` are sampled only on the edge that starts phase 0. A change later in the cycle alters neither strobe until the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| xdata_cyc | input | 1 | Current machine cycle accesses external data memory |
| xexec | input | 1 | Core is executing code from external program memory |
| move_cyc | input | 1 | Current cycle belongs to a code-move or data-move instruction |
| ale_off | input | 1 | Configuration bit that restricts the address-latch strobe |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-fetch read strobe, active low |

## Verification
One external data cycle removes pulses from both strobes at the same time. The disable override also changes `ale` in the same cycles where `psen_n` is pulsing. To provoke these interactions, the bench runs every one of the sixteen combinations of the four control inputs for a full machine cycle. For each combination it checks both strobes at all twelve phases against values computed from the phase number and the sampled controls. Extra cycles change the controls in mid-cycle to a combination that would suppress or restore pulses. In those cycles both strobes must keep the pattern that was sampled at phase 0.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    typedef struct packed {
        logic xdata;
        logic xexec;
        logic move;
        logic ale_off;
    } cyc_ctl_t;

    localparam cyc_ctl_t CTL_IDLE = '{xdata: 1'b0, xexec: 1'b0, move: 1'b0, ale_off: 1'b0};

    function automatic logic in_window(input int unsigned ph,
                                       input int unsigned start,
                                       input int unsigned width);
        return (ph >= start) && (ph < start + width);
    endfunction

    function automatic logic ale_enabled(input cyc_ctl_t c);
        return !c.ale_off || c.xexec || c.move;
    endfunction

endpackage

// File: rtl/bsg_phase_counter.sv
module bsg_phase_counter #(
    parameter int PHASES = 12,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph_q,
    output logic [PH_W-1:0] ph_nxt,
    output logic            wrap_nxt
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_comb begin
        ph_nxt   = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        wrap_nxt = (ph_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= LAST;
        else     ph_q <= ph_nxt;
    end

    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (ph_q != LAST) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/bsg_ctl_latch.sv
module bsg_ctl_latch
    import bsg_pkg::*;
#(
    parameter int PHASES = 12,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wrap_nxt,
    input  logic [PH_W-1:0] ph_q,
    input  cyc_ctl_t        ctl_in,
    output cyc_ctl_t        ctl_q,
    output cyc_ctl_t        ctl_nxt
);
    always_comb begin
        ctl_nxt = (wrap_nxt && !rst) ? ctl_in : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_nxt;
    end

    // R10: the sampled controls only move when a new machine cycle begins
    a_r10_hold_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (ph_q != '0) |-> $stable(ctl_q));
endmodule

// File: rtl/bsg_strobe_shaper.sv
module bsg_strobe_shaper
    import bsg_pkg::*;
#(
    parameter int PHASES  = 12,
    parameter int PW      = 2,
    parameter int ALE_A   = 0,
    parameter int ALE_B   = 6,
    parameter int PSEN_A  = 3,
    parameter int PSEN_B  = 9,
    localparam int PH_W   = $clog2(PHASES),
    localparam int NSLOT  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] ph_nxt,
    input  cyc_ctl_t        ctl_nxt,
    input  cyc_ctl_t        ctl_q,
    output logic            ale,
    output logic            psen_n
);
    localparam int ALE_AT  [NSLOT] = '{ALE_A, ALE_B};
    localparam int PSEN_AT [NSLOT] = '{PSEN_A, PSEN_B};

    logic [NSLOT-1:0] ale_hit;
    logic [NSLOT-1:0] psen_hit;
    logic             ale_d;
    logic             psen_d;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_comb begin
            ale_hit[i]  = in_window(int'(ph_nxt), ALE_AT[i],  PW);
            psen_hit[i] = in_window(int'(ph_nxt), PSEN_AT[i], PW);
        end
    end

    always_comb begin
        if (ale_enabled(ctl_nxt))
            ale_d = ale_hit[0] || (ale_hit[1] && !ctl_nxt.xdata);
        else
            ale_d = 1'b1;
        psen_d = !(ctl_nxt.xexec && !ctl_nxt.xdata && (|psen_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale    <= 1'b0;
            psen_n <= 1'b1;
        end else begin
            ale    <= ale_d;
            psen_n <= psen_d;
        end
    end

    a_r5_psen_quiet_xdata: assert property (@(posedge clk) disable iff (rst)
        ctl_q.xdata |-> psen_n);
    a_r6_psen_needs_xexec: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> ctl_q.xexec);
    a_r7_ale_held_high: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ale_off && !ctl_q.xexec && !ctl_q.move) |-> ale);
    a_r4_psen_width: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n);
    a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bsg_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int PW     = 2,
    parameter int ALE_A  = 0,
    parameter int ALE_B  = 6,
    parameter int PSEN_A = 3,
    parameter int PSEN_B = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic xdata_cyc,
    input  logic xexec,
    input  logic move_cyc,
    input  logic ale_off,
    output logic ale,
    output logic psen_n
);
    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_nxt;
    logic            wrap_nxt;
    cyc_ctl_t        ctl_in;
    cyc_ctl_t        ctl_q;
    cyc_ctl_t        ctl_nxt;

    always_comb begin
        ctl_in = '{xdata: xdata_cyc, xexec: xexec, move: move_cyc, ale_off: ale_off};
    end

    bsg_phase_counter #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nxt(ph_nxt), .wrap_nxt(wrap_nxt)
    );

    bsg_ctl_latch #(.PHASES(PHASES)) u_ctl (
        .clk(clk), .rst(rst), .wrap_nxt(wrap_nxt), .ph_q(ph_q),
        .ctl_in(ctl_in), .ctl_q(ctl_q), .ctl_nxt(ctl_nxt)
    );

    bsg_strobe_shaper #(
        .PHASES(PHASES), .PW(PW), .ALE_A(ALE_A), .ALE_B(ALE_B),
        .PSEN_A(PSEN_A), .PSEN_B(PSEN_B)
    ) u_shape (
        .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .ctl_nxt(ctl_nxt), .ctl_q(ctl_q),
        .ale(ale), .psen_n(psen_n)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!ale && psen_n));
endmodule

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xdata_cyc = 1'b0, xexec = 1'b0, move_cyc = 1'b0, ale_off = 1'b0;
    logic ale, psen_n;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    bus_strobe_gen u0 (
        .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .xexec(xexec),
        .move_cyc(move_cyc), .ale_off(ale_off), .ale(ale), .psen_n(psen_n)
    );

    // control encoding: bit3 xdata_cyc, bit2 xexec, bit1 move_cyc, bit0 ale_off
    task automatic drive(input logic [3:0] c);
        {xdata_cyc, xexec, move_cyc, ale_off} = c;
    endtask

    function automatic logic exp_ale(input int k, input logic [3:0] c);
        logic en = !c[0] || c[2] || c[1];
        if (!en) return 1'b1;
        return (k == 0 || k == 1) || ((k == 6 || k == 7) && !c[3]);
    endfunction

    function automatic logic exp_psen(input int k, input logic [3:0] c);
        return !(c[2] && !c[3] && (k == 3 || k == 4 || k == 9 || k == 10));
    endfunction

    function automatic string ale_tag(input int k, input logic [3:0] c);
        if (c[0] && !c[2] && !c[1]) return "R7";
        if (c[0] && c[2])           return "R9";
        if (c[0] && c[1])           return "R8";
        if (c[3] && (k == 6 || k == 7)) return "R3";
        return "R2";
    endfunction

    function automatic string psen_tag(input logic [3:0] c);
        if (c[3])  return "R5";
        if (!c[2]) return "R6";
        return "R4";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp, input int k);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s phase=%0d actual=%b expected=%b", tag, what, k, act, exp);
        end
    endtask

    initial begin
        logic [3:0] seq [0:19];
        logic [3:0] mid [0:19];
        bit         mid_en [0:19];
        for (int i = 0; i < 16; i++) begin
            seq[i] = 4'(i); mid[i] = 4'b0; mid_en[i] = 1'b0;
        end
        // R10: mid-cycle changes must not take effect until the next cycle
        seq[16] = 4'b0100; mid[16] = 4'b1100; mid_en[16] = 1'b1;
        seq[17] = 4'b1100; mid[17] = 4'b0000; mid_en[17] = 1'b0;
        seq[18] = 4'b0001; mid[18] = 4'b0000; mid_en[18] = 1'b1;
        seq[19] = 4'b0000; mid[19] = 4'b0000; mid_en[19] = 1'b0;

        drive(4'b1111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ale", ale, 1'b0, -1);
        check("R1", "psen_n", psen_n, 1'b1, -1);
        rst = 1'b0;
        drive(seq[0]);
        for (int c = 0; c < 20; c++) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (c == 16 || c == 18) begin
                    check("R10", "ale", ale, exp_ale(k, seq[c]), k);
                    check("R10", "psen_n", psen_n, exp_psen(k, seq[c]), k);
                end else begin
                    check(ale_tag(k, seq[c]), "ale", ale, exp_ale(k, seq[c]), k);
                    check(psen_tag(seq[c]), "psen_n", psen_n, exp_psen(k, seq[c]), k);
                end
                if (k == 2 && mid_en[c]) drive(mid[c]);
                if (k == 11 && c < 19) drive(seq[c + 1]);
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule